// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking tables held in memory. A walk starts with one read from a context table, addressed by a context-table pointer and a context number. It continues through at most three levels of page tables. Any of the three levels may end the walk with a leaf entry, which maps a 16 MB, 256 KB or 4 KB page. All table reads go through one 32-bit read/write port that has a single transaction outstanding and a request/acknowledge handshake with an error flag.

When a leaf is found, the walker reports the leaf entry, the physical address and a page-size code. If the leaf still lacks its referenced bit, or lacks its modified bit on a write access, the walker first sets the missing bits and writes the entry back to the address it was read from. A walk stops at the first fault it meets. The fault code records the kind of fault and the level of the table that produced it. Permission checking and translation caching belong to the surrounding logic.

Top module: `tbl_walker`

## Requirements
- R1: The first read of a walk goes to address {ptr, 4'b0} + {ctx, 2'b00}, formed from the context-table pointer and context number sampled with the start request. This read is level 0.
- R2: Entry bits [1:0] give the type: 0 invalid, 1 pointer, 2 leaf, 3 reserved. A pointer read at level L (L below 3) leads to a read at level L+1. That read's address is ({entry[31:2], 2'b00} << 4) plus an index: VA[31:24]*4 for level 1, VA[23:18]*4 for level 2, VA[17:12]*4 for level 3.
- R3: A leaf at level 1, 2 or 3 ends the walk with fault code 0. It reports page_size_o of 3 (16 MB), 2 (256 KB) or 1 (4 KB). paddr_o is {entry[31:8], 12'b0} plus VA[23:12]<<12 at level 1, plus VA[17:12]<<12 at level 2, or plus nothing at level 3.
- R4: An invalid entry at level L ends the walk with fault code (L<<8)|0x004. entry_o holds the entry, paddr_o is 0 and page_size_o is 0.
- R5: Three cases end the walk with fault code (L<<8)|0x010 and page_size_o 0: a reserved entry at any level, a leaf in the context table (level 0), and a pointer at level 3.
- R6: An error flag on the acknowledge of a table read at level L ends the walk with fault code (L<<8)|0x010 and entry_o 0. No further memory access is made.
- R7: A leaf whose referenced bit (bit 5) is clear, or a leaf hit by a write access while its modified bit (bit 6) is clear, causes exactly one write to the address it was read from. The written value sets bit 5, and also bit 6 on a write access. entry_o shows the written value.
- R8: A leaf that needs no bit update causes no write, and entry_o equals the entry as read.
- R9: busy_o rises in the cycle after an accepted start and stays high through the single-cycle done_o pulse. It is low in the cycle after done_o.
- R10: A start request while busy_o is high is ignored: the running walk's result is unchanged and it produces exactly one done_o pulse.
- R11: Once raised, mem_req_o stays high with stable address and write flag until mem_ack_i is seen.
- R12: Out of reset, busy_o, done_o and mem_req_o are low and fault_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| is_write_i | input | 1 | Access is a write (affects modified-bit update) |
| ctx_ptr_i | input | 32 | Context-table pointer, physical address >> 4 |
| ctx_num_i | input | CTX_W | Context number |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: result outputs are valid |
| fault_o | output | 10 | Fault code: level in [9:8], kind in [4:2]; 0 on success |
| entry_o | output | 32 | Final entry (after update) |
| paddr_o | output | 36 | Translated physical address |
| page_size_o | output | 2 | 0 none, 1 4 KB, 2 256 KB, 3 16 MB |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 36 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge (one cycle) |
| mem_err_i | input | 1 | Bus error, qualified by acknowledge |
| mem_rdata_i | input | 32 | Read data, qualified by acknowledge |

## Verification
The bench aims at the edges of the walk. A leaf in the context table must fault rather than map a page. A pointer in the last table must fault rather than trigger a fourth read. A bus error must fault at its own level without its zero data being decoded as an invalid entry. A design that confused these would report the wrong level or kind, or keep reading. For write-back, the bench counts the write cycles the memory sees. A design that skipped the update, wrote back when both bits were already set, or set the modified bit on a read would show a wrong count or wrong stored entry. Starts injected during a running walk would show up as a changed result or a second done pulse if the design did not drop them.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int ENT_W   = 32;
  localparam int VA_W    = 32;
  localparam int PA_W    = 36;
  localparam int LVL_W   = 2;
  localparam int FC_W    = 10;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam int PFN_LSB = 8;
  localparam int PG_SH   = 12;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;

  typedef enum logic [1:0] {ET_INVALID, ET_PTR, ET_LEAF, ET_RSVD} etype_e;
  typedef enum logic [1:0] {PS_NONE, PS_4K, PS_256K, PS_16M} psize_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WBACK, ST_FIN} wstate_e;

  // Fault word: level in [9:8], fault kind in [4:2].
  function automatic logic [FC_W-1:0] fault_code(input logic [LVL_W-1:0] lvl,
                                                 input logic [2:0] kind);
    return {lvl, 3'b000, kind, 2'b00};
  endfunction

  // Address of the context-table slot.
  function automatic logic [PA_W-1:0] root_addr(input logic [31:0] ptr,
                                                input logic [31:0] ctx);
    return {ptr, 4'b0000} + {2'b00, ctx, 2'b00};
  endfunction

  // Address of the slot read at level lvl_next, from the pointer entry above it.
  function automatic logic [PA_W-1:0] next_addr(input logic [ENT_W-1:0] ent,
                                                input logic [VA_W-1:0] va,
                                                input logic [LVL_W-1:0] lvl_next);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] idx;
    base = {ent[31:2], 2'b00, 4'b0000};
    case (lvl_next)
      2'd1:    idx = {26'b0, va[31:24], 2'b00};
      2'd2:    idx = {28'b0, va[23:18], 2'b00};
      default: idx = {28'b0, va[17:12], 2'b00};
    endcase
    return base + idx;
  endfunction

  // Physical address of a leaf found at level lvl.
  function automatic logic [PA_W-1:0] leaf_paddr(input logic [ENT_W-1:0] ent,
                                                 input logic [VA_W-1:0] va,
                                                 input logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] frame;
    logic [PA_W-1:0] offs;
    frame = {ent[ENT_W-1:PFN_LSB], {PG_SH{1'b0}}};
    case (lvl)
      2'd1:    offs = {12'b0, va[23:12], {PG_SH{1'b0}}};
      2'd2:    offs = {18'b0, va[17:12], {PG_SH{1'b0}}};
      default: offs = '0;
    endcase
    return frame + offs;
  endfunction

  function automatic psize_e leaf_size(input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd1:    return PS_16M;
      2'd2:    return PS_256K;
      2'd3:    return PS_4K;
      default: return PS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tw_entry_dec.sv
module tw_entry_dec
  import tw_pkg::*;
(
  input  logic [ENT_W-1:0] entry_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             bus_err_i,
  output logic             descend_o,
  output logic             leaf_o,
  output logic [FC_W-1:0]  fault_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = '1;
  localparam logic [LVL_W-1:0] ROOT_LVL = '0;

  etype_e ety;
  assign ety = etype_e'(entry_i[1:0]);

  always_comb begin
    descend_o = 1'b0;
    leaf_o    = 1'b0;
    fault_o   = '0;
    if (bus_err_i) begin
      fault_o = fault_code(lvl_i, FT_XLATE);
    end else begin
      case (ety)
        ET_INVALID: fault_o = fault_code(lvl_i, FT_INVALID);
        ET_RSVD:    fault_o = fault_code(lvl_i, FT_XLATE);
        ET_PTR: begin
          if (lvl_i == LAST_LVL) fault_o = fault_code(lvl_i, FT_XLATE);
          else                   descend_o = 1'b1;
        end
        default: begin
          if (lvl_i == ROOT_LVL) fault_o = fault_code(lvl_i, FT_XLATE);
          else                   leaf_o = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/tw_wb_calc.sv
module tw_wb_calc
  import tw_pkg::*;
(
  input  logic [ENT_W-1:0] entry_i,
  input  logic             is_write_i,
  output logic             need_o,
  output logic [ENT_W-1:0] entry_o
);
  logic miss_ref;
  logic miss_mod;

  assign miss_ref = ~entry_i[REF_BIT];
  assign miss_mod = is_write_i & ~entry_i[MOD_BIT];
  assign need_o   = miss_ref | miss_mod;

  always_comb begin
    entry_o          = entry_i;
    entry_o[REF_BIT] = 1'b1;
    if (is_write_i) entry_o[MOD_BIT] = 1'b1;
  end
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import tw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic               is_write_i,
  input  logic [31:0]        ctx_ptr_i,
  input  logic [CTX_W-1:0]   ctx_num_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FC_W-1:0]    fault_o,
  output logic [ENT_W-1:0]   entry_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic [1:0]         page_size_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [PA_W-1:0]    mem_addr_o,
  output logic [ENT_W-1:0]   mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic               mem_err_i,
  input  logic [ENT_W-1:0]   mem_rdata_i
);
  wstate_e          st_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;
  logic [VA_W-1:0]  va_q;
  logic [ENT_W-1:0] entry_q;
  logic             wr_q;
  logic [FC_W-1:0]  fault_q;
  psize_e           size_q;

  // Named events for the sequencer and its assertions.
  logic             rd_done;
  logic             wb_done;
  logic             dec_descend;
  logic             dec_leaf;
  logic [FC_W-1:0]  dec_fault;
  logic             dec_faulted;
  logic             wb_need;
  logic [ENT_W-1:0] wb_entry;
  logic [LVL_W-1:0] lvl_nxt;

  assign rd_done     = (st_q == ST_READ)  && mem_ack_i;
  assign wb_done     = (st_q == ST_WBACK) && mem_ack_i;
  assign dec_faulted = (dec_fault != '0);
  assign lvl_nxt     = lvl_q + LVL_W'(1);

  tw_entry_dec u_dec (
    .entry_i   (mem_rdata_i),
    .lvl_i     (lvl_q),
    .bus_err_i (mem_err_i),
    .descend_o (dec_descend),
    .leaf_o    (dec_leaf),
    .fault_o   (dec_fault)
  );

  tw_wb_calc u_wb (
    .entry_i    (mem_rdata_i),
    .is_write_i (wr_q),
    .need_o     (wb_need),
    .entry_o    (wb_entry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lvl_q   <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      va_q    <= '0;
      entry_q <= '0;
      wr_q    <= 1'b0;
      fault_q <= '0;
      size_q  <= PS_NONE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            va_q    <= vaddr_i;
            wr_q    <= is_write_i;
            lvl_q   <= '0;
            addr_q  <= root_addr(ctx_ptr_i, 32'(ctx_num_i));
            fault_q <= '0;
            entry_q <= '0;
            paddr_q <= '0;
            size_q  <= PS_NONE;
            st_q    <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_done) begin
            entry_q <= mem_err_i ? '0 : mem_rdata_i;
            if (dec_faulted) begin
              fault_q <= dec_fault;
              st_q    <= ST_FIN;
            end else if (dec_descend) begin
              lvl_q  <= lvl_nxt;
              addr_q <= next_addr(mem_rdata_i, va_q, lvl_nxt);
            end else if (dec_leaf) begin
              paddr_q <= leaf_paddr(mem_rdata_i, va_q, lvl_q);
              size_q  <= leaf_size(lvl_q);
              if (wb_need) begin
                entry_q <= wb_entry;
                st_q    <= ST_WBACK;
              end else begin
                st_q <= ST_FIN;
              end
            end
          end
        end
        ST_WBACK: if (wb_done) st_q <= ST_FIN;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign fault_o     = fault_q;
  assign entry_o     = entry_q;
  assign paddr_o     = paddr_q;
  assign page_size_o = size_q;
  assign mem_req_o   = (st_q == ST_READ) || (st_q == ST_WBACK);
  assign mem_we_o    = (st_q == ST_WBACK);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = entry_q;

  // ---------------- assertions ----------------
  p_reset_idle_r12: assert property (@(posedge clk)
    !rst_n |=> !busy_o && !mem_req_o && fault_o == '0);

  p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> mem_req_o && !mem_we_o &&
      mem_addr_o == ({$past(ctx_ptr_i), 4'b0000} + ({4'b0000, 32'($past(ctx_num_i))} << 2)));

  p_descend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && dec_descend |=> mem_req_o && !mem_we_o && lvl_q == $past(lvl_q) + LVL_W'(1));

  p_leaf_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o == '0 |-> page_size_o != 2'd0);

  p_fault_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o != '0 |-> fault_o[1:0] == 2'b00 && fault_o[7:5] == 3'b000 &&
      (fault_o[4:2] == FT_INVALID || fault_o[4:2] == FT_XLATE) && page_size_o == 2'd0);

  p_bus_err_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && mem_err_i |=> done_o && !mem_req_o);

  p_wb_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> mem_wdata_o[REF_BIT] && (!wr_q || mem_wdata_o[MOD_BIT]));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(va_q) && $stable(wr_q));

  p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

// File: tb/tbl_walker_tb.sv
module tbl_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CTX_W = 8;
  localparam logic [5:0] FL_REF = 6'b001000;
  localparam logic [5:0] FL_MOD = 6'b010000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] vaddr = '0;
  logic is_wr = 1'b0;
  logic [31:0] ctx_ptr = '0;
  logic [CTX_W-1:0] ctx_num = '0;
  logic busy_o, done_o;
  logic [9:0] fault_o;
  logic [31:0] entry_o;
  logic [35:0] paddr_o;
  logic [1:0] page_size_o;
  logic mem_req_o, mem_we_o;
  logic [35:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic mem_ack = 1'b0;
  logic mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [logic [35:0]];
  bit err_en = 0;
  logic [35:0] err_addr = '0;
  bit seen_first = 0;
  logic [35:0] first_addr = '0;
  int wr_cnt = 0;
  int done_cnt = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbl_walker #(.CTX_W(CTX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vaddr_i(vaddr), .is_write_i(is_wr),
    .ctx_ptr_i(ctx_ptr), .ctx_num_i(ctx_num), .busy_o(busy_o), .done_o(done_o),
    .fault_o(fault_o), .entry_o(entry_o), .paddr_o(paddr_o), .page_size_o(page_size_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata)
  );

  // Memory responder: random latency, one-cycle acknowledge.
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end else if (mem_req_o) begin
        if (lat > 0) lat--;
        else begin
          if (!seen_first) begin first_addr = mem_addr_o; seen_first = 1; end
          mem_err = err_en && !mem_we_o && (mem_addr_o == err_addr);
          if (mem_we_o) begin
            wr_cnt++;
            mem[mem_addr_o] = mem_wdata_o;
          end
          mem_rdata = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
          mem_ack = 1'b1;
          lat = $urandom_range(0, 2);
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done_o) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tbl_index(input logic [31:0] va, input int lv);
    if (lv == 1) return (va >> 22) & 32'h3fc;
    if (lv == 2) return (va >> 16) & 32'hfc;
    return (va >> 10) & 32'hfc;
  endfunction

  function automatic logic [35:0] root_of(input logic [31:0] ptr, input logic [CTX_W-1:0] ctx);
    return (36'(ptr) << 4) + (36'(ctx) << 2);
  endfunction

  // Reference walk over the bench memory.
  function automatic void model(input logic [31:0] va, input bit wr, input logic [31:0] ptr,
                                input logic [CTX_W-1:0] ctx,
                                output logic [9:0] f, output logic [31:0] e,
                                output logic [35:0] pa, output logic [1:0] sz,
                                output logic [35:0] la, output bit wb);
    logic [35:0] a;
    logic [31:0] ent;
    bit fin;
    a = root_of(ptr, ctx);
    f = '0; e = '0; pa = '0; sz = '0; la = '0; wb = 0; fin = 0;
    for (int lv = 0; lv < 4 && !fin; lv++) begin
      la = a;
      if (err_en && a == err_addr) begin
        f = 10'(lv * 256 + 16); e = '0; fin = 1;
      end else begin
        ent = mem.exists(a) ? mem[a] : 32'h0;
        e = ent;
        if (ent[1:0] == 2'd0) begin
          f = 10'(lv * 256 + 4); fin = 1;
        end else if (ent[1:0] == 2'd3 || (ent[1:0] == 2'd1 && lv == 3) ||
                     (ent[1:0] == 2'd2 && lv == 0)) begin
          f = 10'(lv * 256 + 16); fin = 1;
        end else if (ent[1:0] == 2'd1) begin
          a = (36'(ent & ~32'h3) << 4) + 36'(tbl_index(va, lv + 1));
        end else begin
          if (lv == 1) begin pa = (36'(ent >> 8) << 12) + 36'(va & 32'h00fff000); sz = 2'd3; end
          else if (lv == 2) begin pa = (36'(ent >> 8) << 12) + 36'(va & 32'h0003f000); sz = 2'd2; end
          else begin pa = 36'(ent >> 8) << 12; sz = 2'd1; end
          if (!ent[5] || (wr && !ent[6])) begin
            wb = 1;
            e = ent | 32'h20 | (wr ? 32'h40 : 32'h0);
          end
          fin = 1;
        end
      end
    end
  endfunction

  // Lay down a chain of pointers ending at stop_lvl with the given type.
  task automatic chain(input logic [31:0] ptr, input logic [CTX_W-1:0] ctx, input logic [31:0] va,
                       input int stop_lvl, input logic [1:0] last_type, input logic [5:0] flags,
                       output logic [35:0] last_addr);
    logic [35:0] a;
    logic [31:0] e;
    mem.delete();
    a = root_of(ptr, ctx);
    for (int lv = 0; lv <= stop_lvl; lv++) begin
      e = $urandom();
      if (lv < stop_lvl) begin
        e[1:0] = 2'b01;
        mem[a] = e;
        a = (36'(e & ~32'h3) << 4) + 36'(tbl_index(va, lv + 1));
      end else begin
        e[7:2] = flags;
        e[1:0] = last_type;
        mem[a] = e;
        last_addr = a;
      end
    end
  endtask

  logic [9:0] got_fault;

  task automatic run_walk(input logic [31:0] va, input bit wr, input logic [31:0] ptr,
                          input logic [CTX_W-1:0] ctx, input bit poke, input string tag);
    logic [9:0] ef; logic [31:0] ee; logic [35:0] epa; logic [1:0] esz;
    logic [35:0] ela; bit ewb; int wc0; int d0; int n;
    model(va, wr, ptr, ctx, ef, ee, epa, esz, ela, ewb);
    @(negedge clk);
    seen_first = 0; wc0 = wr_cnt; d0 = done_cnt;
    vaddr = va; is_wr = wr; ctx_ptr = ptr; ctx_num = ctx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", 64'(busy_o), 64'(1));
    if (poke) begin vaddr = ~va; is_wr = ~wr; ctx_ptr = ~ptr; end
    n = 0;
    while (!done_o && n < 200) begin
      start = poke;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done_o == 1'b1, "R9", "done seen", 64'(done_o), 64'(1));
    chk(busy_o == 1'b1, "R9", "busy during done", 64'(busy_o), 64'(1));
    got_fault = fault_o;
    chk(first_addr == root_of(ptr, ctx), "R1", "first read address", 64'(first_addr),
        64'(root_of(ptr, ctx)));
    chk(fault_o == ef, tag, "fault code", 64'(fault_o), 64'(ef));
    chk(entry_o == ee, tag, "entry", 64'(entry_o), 64'(ee));
    chk(paddr_o == epa, tag, "paddr", 64'(paddr_o), 64'(epa));
    chk(page_size_o == esz, tag, "page size", 64'(page_size_o), 64'(esz));
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0, "R9", "idle after done", 64'(busy_o), 64'(0));
    chk(done_cnt == d0 + 1, poke ? "R10" : "R9", "done pulses", 64'(done_cnt - d0), 64'(1));
    chk(wr_cnt - wc0 == (ewb ? 1 : 0), ewb ? "R7" : "R8", "write count",
        64'(wr_cnt - wc0), 64'(ewb ? 1 : 0));
    if (ewb) chk(mem[ela] == ee, "R7", "stored entry", 64'(mem[ela]), 64'(ee));
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] la;
    logic [31:0] va, ptr;
    logic [CTX_W-1:0] ctx;
    int sl;
    logic [1:0] ty;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(busy_o == 1'b0, "R12", "busy in reset", 64'(busy_o), 64'(0));
    chk(mem_req_o == 1'b0, "R12", "req in reset", 64'(mem_req_o), 64'(0));
    chk(done_o == 1'b0, "R12", "done in reset", 64'(done_o), 64'(0));
    chk(fault_o == '0, "R12", "fault in reset", 64'(fault_o), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R7: 16 MB leaf, referenced bit clear, read access
    va = 32'h12345678; ptr = 32'h0001_0000; ctx = 8'h05;
    chain(ptr, ctx, va, 1, 2'd2, 6'b000000, la);
    run_walk(va, 0, ptr, ctx, 0, "R3");
    chk(page_size_o == 2'd3, "R3", "16MB code", 64'(page_size_o), 64'(3));
    // R7: 256 KB leaf, write, referenced set, modified clear
    chain(ptr, ctx, va, 2, 2'd2, FL_REF, la);
    run_walk(va, 1, ptr, ctx, 0, "R7");
    chk(entry_o[6] == 1'b1, "R7", "modified set", 64'(entry_o[6]), 64'(1));
    // R8: 4 KB leaf, write, both bits set
    chain(ptr, ctx, 32'hfedcb000, 3, 2'd2, FL_REF | FL_MOD, la);
    run_walk(32'hfedcb000, 1, ptr, ctx, 0, "R8");
    chk(page_size_o == 2'd1, "R3", "4KB code", 64'(page_size_o), 64'(1));
    // R8: read access, referenced set, modified clear -> no write
    chain(ptr, ctx, va, 3, 2'd2, FL_REF, la);
    run_walk(va, 0, ptr, ctx, 0, "R8");
    // R4: invalid context entry
    chain(ptr, ctx, va, 0, 2'd0, 6'b0, la);
    run_walk(va, 0, ptr, ctx, 0, "R4");
    chk(got_fault == 10'h004, "R4", "invalid at level 0", 64'(got_fault), 64'h004);
    // R5: leaf in context table
    chain(ptr, ctx, va, 0, 2'd2, 6'b0, la);
    run_walk(va, 0, ptr, ctx, 0, "R5");
    chk(got_fault == 10'h010, "R5", "leaf at level 0", 64'(got_fault), 64'h010);
    // R5: pointer at last level
    chain(ptr, ctx, va, 3, 2'd1, 6'b0, la);
    run_walk(va, 0, ptr, ctx, 0, "R5");
    chk(got_fault == 10'h310, "R5", "pointer at level 3", 64'(got_fault), 64'h310);
    // R5: reserved at level 1
    chain(ptr, ctx, va, 1, 2'd3, 6'b0, la);
    run_walk(va, 0, ptr, ctx, 0, "R5");
    chk(got_fault == 10'h110, "R5", "reserved at level 1", 64'(got_fault), 64'h110);
    // R6: bus error on the level-2 read
    chain(ptr, ctx, va, 2, 2'd2, 6'b0, la);
    err_en = 1; err_addr = la;
    run_walk(va, 0, ptr, ctx, 0, "R6");
    chk(got_fault == 10'h210, "R6", "bus error at level 2", 64'(got_fault), 64'h210);
    err_en = 0;
    // R10: start held during a running walk
    chain(ptr, ctx, va, 3, 2'd2, 6'b0, la);
    run_walk(va, 1, ptr, ctx, 1, "R10");

    // Random walks (R2 covers the chained descent)
    for (int i = 0; i < 160; i++) begin
      va = $urandom(); ptr = $urandom(); ctx = CTX_W'($urandom());
      sl = $urandom_range(0, 3);
      ty = ($urandom_range(0, 9) < 7) ? 2'd2 : 2'($urandom_range(0, 3));
      chain(ptr, ctx, va, sl, ty, 6'($urandom()), la);
      err_en = ($urandom_range(0, 9) == 0);
      err_addr = la;
      run_walk(va, 1'($urandom()), ptr, ctx, ($urandom_range(0, 7) == 0), "R2");
      err_en = 0;
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule